// File: doc/BRIEF.md
# Watchdog Timer with Tick Prescaler

The block is a supervisory timer that software must keep refreshing. A prescaler divides the block clock into timebase ticks. A 24-bit down-counter falls by two on every tick. When the count runs out, the block raises a one-cycle request to the chip reset controller. Software can also demand a reset at once through a control bit.

Counting stops while the timer is disabled. It also stops while any of three debug-activity inputs is high and its pause mask bit is set. A two-bit cause field records whether the most recent request came from expiry or was forced. Eight scratch words hold data across the reset that the block requests. Only the block's own power-on reset clears the cause field and the scratch words.

Access goes through a simple word-addressed port. A write takes effect at the clock edge on which `wr_en_i` is high. Reads are combinational from `addr_i`. The word addresses are: 0 control, 1 reload, 2 cause, 3 prescaler, and 8 to 15 for the scratch words.

Top module: `wdt_top`

## Requirements
- R1: After `rst_ni` the block reads as follows. Control (addr 0) reads 0x0700_0000, which means disabled, all three masks set and count 0. Prescaler (addr 3) reads 0x0000_0200, which means generation on, period 0 and not running. Cause (addr 2), reload (addr 1) and every scratch word read 0, and `wdog_rst_o` is low.
- R2: A write to the reload register (addr 1) sets the counter, visible in control bits 23:0 from the next cycle on. The reload register always reads 0.
- R3: The counter holds while control bit 30 (enable) is 0. It also holds while a debug input is high and its mask is set: bit 26 masks `dbg_cpu1_i`, bit 25 masks `dbg_cpu0_i`, and bit 24 masks `dbg_port_i`. A high input whose mask is clear has no effect.
- R4: Each tick that is not held lowers the counter by exactly 2.
- R5: A tick that arrives with the count at 2 or below sets the count to 0. `wdog_rst_o` then goes high for the cycle after that edge, and the cause reads 0b01 (bit 0 = timer).
- R6: A control write with bit 31 set raises `wdog_rst_o` for the following cycle and makes the cause read 0b10 (bit 1 = forced). Bit 31 always reads 0.
- R7: With prescaler bit 9 set and a period N > 0 in bits 8:0, a tick occurs every N clock cycles. Bit 10 then reads 1. Bits 19:11 read the remaining cycles, which step N, N-1, ..., 1 and then back to N.
- R8: With a period of 0, or with bit 9 clear, no ticks occur and bit 10 reads 0.
- R9: The eight scratch words (addr 8 to 15) each store and return a full 32-bit value independently.
- R10: The cause field and the scratch words keep their values across requests from the block. Only `rst_ni` clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block and reference clock |
| rst_ni | input | 1 | Active-low asynchronous power-on reset |
| wr_en_i | input | 1 | Write strobe for the addressed register |
| addr_i | input | 4 | Word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Combinational read data for `addr_i` |
| dbg_cpu0_i | input | 1 | Processor-0 debug activity |
| dbg_cpu1_i | input | 1 | Processor-1 debug activity |
| dbg_port_i | input | 1 | Debug-port bus access activity |
| wdog_rst_o | output | 1 | One-cycle reset request |

## Verification
Register writes become visible on the first read after their write edge. A forced request raises `wdog_rst_o` in the cycle right after the write edge. The bench drives every input on the falling edge and samples on the falling edge that follows, so each result is read exactly one edge after its cause. The timed behaviour is timed by counting falling edges between observed changes: tick spacing, the step of two, and the expiry pulse. After an expiry pulse is seen, the very next sample must be low again.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int DATA_W = 32;

  localparam logic [3:0] ADR_CTRL   = 4'h0;
  localparam logic [3:0] ADR_RELOAD = 4'h1;
  localparam logic [3:0] ADR_CAUSE  = 4'h2;
  localparam logic [3:0] ADR_PRESC  = 4'h3;

  localparam int CTRL_TRIG_BIT = 31;
  localparam int CTRL_EN_BIT   = 30;
  localparam int CTRL_MASK_LSB = 24;
  localparam int N_DBG         = 3;
endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int PRE_W = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic [PRE_W-1:0] cfg_cyc_i,
  input  logic             cfg_on_i,
  output logic [PRE_W-1:0] cyc_o,
  output logic             on_o,
  output logic [PRE_W-1:0] remain_o,
  output logic             running_o,
  output logic             tick_o
);
  logic [PRE_W-1:0] cyc_q, cnt_q;
  logic             on_q, run_q;
  logic             idle;

  assign idle = !on_q || (cyc_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cyc_q <= '0;
      on_q  <= 1'b1;
      cnt_q <= '0;
      run_q <= 1'b0;
    end else begin
      if (cfg_we_i) begin
        cyc_q <= cfg_cyc_i;
        on_q  <= cfg_on_i;
      end
      if (idle) begin
        run_q <= 1'b0;
        cnt_q <= '0;
      end else if (!run_q) begin
        run_q <= 1'b1;
        cnt_q <= cyc_q;
      end else if (cnt_q <= PRE_W'(1)) begin
        cnt_q <= cyc_q;
      end else begin
        cnt_q <= cnt_q - PRE_W'(1);
      end
    end
  end

  assign tick_o    = run_q && (cnt_q == PRE_W'(1));
  assign cyc_o     = cyc_q;
  assign on_o      = on_q;
  assign remain_o  = cnt_q;
  assign running_o = run_q;

  // R8: an idle generator emits nothing on the following cycle
  a_r8_no_tick_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle |=> !tick_o);
  // R7: a tick reloads the full period
  a_r7_tick_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && !idle) |=> (remain_o == $past(cyc_q)));
endmodule

// File: rtl/wdt_countdown.sv
module wdt_countdown #(
  parameter int CNT_W = 24,
  parameter int N_DBG = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             en_i,
  input  logic [N_DBG-1:0] dbg_i,
  input  logic [N_DBG-1:0] mask_i,
  input  logic             load_we_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             trig_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             rst_req_o,
  output logic             why_timer_o,
  output logic             why_force_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             rst_q, timer_q, force_q;
  logic             held, step, low, expire;

  assign held   = !en_i || (|(dbg_i & mask_i));
  assign step   = tick_i && !held;
  assign low    = (cnt_q <= CNT_W'(2));
  assign expire = step && !load_we_i && low;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      rst_q   <= 1'b0;
      timer_q <= 1'b0;
      force_q <= 1'b0;
    end else begin
      if (load_we_i)   cnt_q <= load_val_i;
      else if (step)   cnt_q <= low ? '0 : cnt_q - CNT_W'(2);
      rst_q <= expire || trig_i;
      // a forced request outranks a coincident expiry
      if (trig_i) begin
        force_q <= 1'b1;
        timer_q <= 1'b0;
      end else if (expire) begin
        force_q <= 1'b0;
        timer_q <= 1'b1;
      end
    end
  end

  assign cnt_o       = cnt_q;
  assign rst_req_o   = rst_q;
  assign why_timer_o = timer_q;
  assign why_force_o = force_q;

  a_r4_step_two: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !held && !load_we_i && cnt_q > CNT_W'(2)) |=> (cnt_q == $past(cnt_q) - CNT_W'(2)));
  a_r3_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (held && !load_we_i) |=> $stable(cnt_q));
  a_r5_expire_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !held && !load_we_i && !trig_i && low) |=> (rst_req_o && why_timer_o && cnt_q == '0));
  a_r6_force_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_i |=> (rst_req_o && why_force_o && !why_timer_o));
  a_r10_cause_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({why_timer_o, why_force_o}));
endmodule

// File: rtl/wdt_scratch.sv
module wdt_scratch #(
  parameter int N_WORDS = 8,
  parameter int DATA_W  = 32,
  localparam int IDX_W  = $clog2(N_WORDS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] word_q [N_WORDS];

  for (genvar g = 0; g < N_WORDS; g++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                word_q[g] <= '0;
      else if (we_i && (idx_i == IDX_W'(g)))      word_q[g] <= wdata_i;
    end
  end

  assign rdata_o = word_q[idx_i];

  a_r9_write_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (word_q[$past(idx_i)] == $past(wdata_i)));
endmodule

// File: rtl/wdt_top.sv
module wdt_top
  import wdt_pkg::*;
#(
  parameter int CNT_W     = 24,
  parameter int PRE_W     = 9,
  parameter int N_SCRATCH = 8,
  parameter int ADDR_W    = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  input  logic              dbg_cpu0_i,
  input  logic              dbg_cpu1_i,
  input  logic              dbg_port_i,
  output logic              wdog_rst_o
);
  localparam int SCR_IW = $clog2(N_SCRATCH);

  logic             wr_ctrl, wr_reload, wr_presc, wr_scr, trig;
  logic             en_q;
  logic [N_DBG-1:0] mask_q, dbg;
  logic [PRE_W-1:0] cyc, remain;
  logic             on, running, tick;
  logic [CNT_W-1:0] cnt;
  logic             why_timer, why_force;
  logic [31:0]      scr_rd;

  assign wr_ctrl   = wr_en_i && (addr_i == ADDR_W'(ADR_CTRL));
  assign wr_reload = wr_en_i && (addr_i == ADDR_W'(ADR_RELOAD));
  assign wr_presc  = wr_en_i && (addr_i == ADDR_W'(ADR_PRESC));
  assign wr_scr    = wr_en_i && addr_i[ADDR_W-1];
  assign trig      = wr_ctrl && wdata_i[CTRL_TRIG_BIT];
  // mask order: bit 2 processor 1, bit 1 processor 0, bit 0 debug port
  assign dbg       = {dbg_cpu1_i, dbg_cpu0_i, dbg_port_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      mask_q <= '1;
    end else if (wr_ctrl) begin
      en_q   <= wdata_i[CTRL_EN_BIT];
      mask_q <= wdata_i[CTRL_MASK_LSB +: N_DBG];
    end
  end

  wdt_prescaler #(.PRE_W(PRE_W)) u_presc (
    .clk_i, .rst_ni,
    .cfg_we_i (wr_presc),
    .cfg_cyc_i(wdata_i[PRE_W-1:0]),
    .cfg_on_i (wdata_i[PRE_W]),
    .cyc_o    (cyc),
    .on_o     (on),
    .remain_o (remain),
    .running_o(running),
    .tick_o   (tick)
  );

  wdt_countdown #(.CNT_W(CNT_W), .N_DBG(N_DBG)) u_cnt (
    .clk_i, .rst_ni,
    .tick_i     (tick),
    .en_i       (en_q),
    .dbg_i      (dbg),
    .mask_i     (mask_q),
    .load_we_i  (wr_reload),
    .load_val_i (wdata_i[CNT_W-1:0]),
    .trig_i     (trig),
    .cnt_o      (cnt),
    .rst_req_o  (wdog_rst_o),
    .why_timer_o(why_timer),
    .why_force_o(why_force)
  );

  wdt_scratch #(.N_WORDS(N_SCRATCH), .DATA_W(32)) u_scr (
    .clk_i, .rst_ni,
    .we_i   (wr_scr),
    .idx_i  (addr_i[SCR_IW-1:0]),
    .wdata_i(wdata_i),
    .rdata_o(scr_rd)
  );

  always_comb begin
    rdata_o = '0;
    if (addr_i[ADDR_W-1]) begin
      rdata_o = scr_rd;
    end else begin
      case (addr_i)
        ADDR_W'(ADR_CTRL): begin
          rdata_o[CNT_W-1:0]                 = cnt;
          rdata_o[CTRL_EN_BIT]               = en_q;
          rdata_o[CTRL_MASK_LSB +: N_DBG]    = mask_q;
        end
        ADDR_W'(ADR_CAUSE): rdata_o[1:0] = {why_force, why_timer};
        ADDR_W'(ADR_PRESC): begin
          rdata_o[PRE_W-1:0]         = cyc;
          rdata_o[PRE_W]             = on;
          rdata_o[PRE_W+1]           = running;
          rdata_o[PRE_W+2 +: PRE_W]  = remain;
        end
        default: rdata_o = '0;
      endcase
    end
  end

  // R6: a request only follows a trigger write or a tick
  a_r6_req_has_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!trig && !tick) |=> !wdog_rst_o);
endmodule

// File: tb/wdt_top_tb.sv
module wdt_top_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [3:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        dbg_cpu0_i = 1'b0, dbg_cpu1_i = 1'b0, dbg_port_i = 1'b0;
  logic        wdog_rst_o;

  int n_chk = 0, n_fail = 0;
  logic [31:0] rd;

  always #4 clk_i = ~clk_i;

  wdt_top u_dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic rd_reg(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk_i);
    addr_i = a;
    #1 d = rdata_o;
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  task automatic t_reset();
    rd_reg(4'h0, rd); chk("R1 ctrl", rd, 32'h0700_0000);
    rd_reg(4'h3, rd); chk("R1 presc", rd, 32'h0000_0200);
    rd_reg(4'h2, rd); chk("R1 cause", rd, 32'h0);
    rd_reg(4'h1, rd); chk("R1 reload", rd, 32'h0);
    for (int i = 0; i < 8; i++) begin
      rd_reg(4'(8 + i), rd); chk("R1 scratch", rd, 32'h0);
    end
    chk("R1 request", {31'b0, wdog_rst_o}, 32'h0);
  endtask

  task automatic t_reload();
    wr(4'h1, 32'hFF12_3456);
    rd_reg(4'h0, rd); chk("R2 count", {8'h0, rd[23:0]}, 32'h0012_3456);
    rd_reg(4'h1, rd); chk("R2 reload reads 0", rd, 32'h0);
  endtask

  task automatic t_scratch();
    for (int i = 0; i < 8; i++) wr(4'(8 + i), 32'hC3A5_0000 ^ (32'(i) * 32'h0101_1111));
    for (int i = 0; i < 8; i++) begin
      rd_reg(4'(8 + i), rd); chk("R9 scratch", rd, 32'hC3A5_0000 ^ (32'(i) * 32'h0101_1111));
    end
  endtask

  task automatic t_presc();
    logic [8:0] prev, cur;
    int bad = 0;
    wr(4'h3, 32'h0000_0205);
    repeat (3) @(negedge clk_i);
    rd_reg(4'h3, rd);
    chk("R7 running", {31'b0, rd[10]}, 32'h1);
    prev = rd[19:11];
    for (int i = 0; i < 14; i++) begin
      rd_reg(4'h3, rd);
      cur = rd[19:11];
      if (cur != ((prev == 9'd1) ? 9'd5 : prev - 9'd1)) bad++;
      prev = cur;
    end
    chk("R7 remain sequence errors", 32'(bad), 32'h0);
  endtask

  task automatic t_step();
    logic [23:0] c0, c1;
    int gap;
    wr(4'h1, 32'd1000);
    wr(4'h0, 32'h4700_0000);
    rd_reg(4'h0, rd); c0 = rd[23:0];
    for (int i = 0; i < 20; i++) begin
      rd_reg(4'h0, rd);
      if (rd[23:0] != c0) break;
    end
    c0 = rd[23:0];
    gap = 0;
    for (int i = 0; i < 20; i++) begin
      rd_reg(4'h0, rd); gap++;
      if (rd[23:0] != c0) break;
    end
    c1 = rd[23:0];
    chk("R4 step", 32'(c0 - c1), 32'd2);
    chk("R7 tick spacing", 32'(gap), 32'd5);
  endtask

  task automatic t_pause();
    logic [23:0] c0;
    dbg_cpu0_i = 1'b1;
    rd_reg(4'h0, rd); c0 = rd[23:0];
    repeat (20) @(negedge clk_i);
    rd_reg(4'h0, rd); chk("R3 masked pause", {8'h0, rd[23:0]}, {8'h0, c0});
    wr(4'h0, 32'h4500_0000);
    rd_reg(4'h0, rd); c0 = rd[23:0];
    repeat (20) @(negedge clk_i);
    rd_reg(4'h0, rd); chk("R3 unmasked input ignored", {31'b0, rd[23:0] < c0}, 32'h1);
    dbg_cpu0_i = 1'b0;
    dbg_port_i = 1'b1;
    wr(4'h0, 32'h4100_0000);
    rd_reg(4'h0, rd); c0 = rd[23:0];
    repeat (20) @(negedge clk_i);
    rd_reg(4'h0, rd); chk("R3 port pause", {8'h0, rd[23:0]}, {8'h0, c0});
    dbg_port_i = 1'b0;
    wr(4'h0, 32'h0700_0000);
    rd_reg(4'h0, rd); c0 = rd[23:0];
    repeat (20) @(negedge clk_i);
    rd_reg(4'h0, rd); chk("R3 disabled hold", {8'h0, rd[23:0]}, {8'h0, c0});
  endtask

  task automatic t_idle();
    logic [23:0] c0;
    wr(4'h3, 32'h0000_0200);
    wr(4'h0, 32'h4700_0000);
    rd_reg(4'h3, rd); chk("R8 period 0 not running", {31'b0, rd[10]}, 32'h0);
    rd_reg(4'h0, rd); c0 = rd[23:0];
    repeat (20) @(negedge clk_i);
    rd_reg(4'h0, rd); chk("R8 period 0 no ticks", {8'h0, rd[23:0]}, {8'h0, c0});
    wr(4'h3, 32'h0000_0005);
    rd_reg(4'h3, rd); chk("R8 gen off not running", {31'b0, rd[10]}, 32'h0);
    repeat (20) @(negedge clk_i);
    rd_reg(4'h0, rd); chk("R8 gen off no ticks", {8'h0, rd[23:0]}, {8'h0, c0});
    wr(4'h0, 32'h0700_0000);
  endtask

  task automatic t_expire();
    int seen = 0;
    wr(4'h3, 32'h0000_0205);
    wr(4'h1, 32'd6);
    wr(4'h0, 32'h4700_0000);
    for (int i = 0; i < 40; i++) begin
      @(negedge clk_i);
      if (wdog_rst_o) begin seen = 1; break; end
    end
    chk("R5 request seen", 32'(seen), 32'h1);
    @(negedge clk_i);
    chk("R5 one-cycle pulse", {31'b0, wdog_rst_o}, 32'h0);
    wr(4'h0, 32'h0700_0000);
    rd_reg(4'h0, rd); chk("R5 count zero", {8'h0, rd[23:0]}, 32'h0);
    rd_reg(4'h2, rd); chk("R5 cause timer", rd, 32'h1);
  endtask

  task automatic t_force();
    wr(4'h0, 32'h8700_0000);
    chk("R6 request", {31'b0, wdog_rst_o}, 32'h1);
    @(negedge clk_i);
    chk("R6 one-cycle pulse", {31'b0, wdog_rst_o}, 32'h0);
    rd_reg(4'h2, rd); chk("R6 cause forced", rd, 32'h2);
    rd_reg(4'h0, rd); chk("R6 trigger reads 0", {31'b0, rd[31]}, 32'h0);
  endtask

  task automatic t_retain();
    rd_reg(4'hB, rd); chk("R10 scratch kept", rd, 32'hC3A5_0000 ^ 32'h0303_3333);
    rd_reg(4'h2, rd); chk("R10 cause kept", rd, 32'h2);
    do_reset();
    rd_reg(4'hB, rd); chk("R10 scratch cleared", rd, 32'h0);
    rd_reg(4'h2, rd); chk("R10 cause cleared", rd, 32'h0);
  endtask

  initial begin
    repeat (50000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    do_reset();
    t_reset();
    t_reload();
    t_scratch();
    t_presc();
    t_step();
    t_pause();
    t_idle();
    t_expire();
    t_force();
    t_retain();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule